// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches one bus-cycle descriptor per clock on a processor bus and raises a break request whenever a cycle meets a condition that software has programmed. Two channels, A and B, work independently. Each compares the cycle address against a break address under a don't-care mask, requires an exact address-space identifier, and qualifies the cycle by bus master (CPU or DMA controller), by kind (instruction fetch or data access), by direction and by operand size. Channel B can also compare the bus data against a break value under a data mask.

Address matching works on the access footprint. An access covers the aligned span of its operand size, so a longword access whose four bytes include the break address hits as well. Data comparison is aligned to the operand size. Each hit sets a sticky per-channel flag. Software clears the flag through the same register-write port that programs the conditions, and a combined break request is the OR of both flags.

Top module: `brk_compare_unit`

## Requirements
- R1: After reset both flags and `brk_req` are 0, and every condition register is 0. A condition value of 0 selects no direction, so no bus cycle can set a flag until the channel is programmed.
- R2: Address compare: a cycle hits only if `(cyc_addr ^ brk_addr) & ~(addr_mask | span)` is zero. A mask bit of 1 is a don't-care. Register indices for channel A are 0 (address), 1 (mask), 2 (identifier) and 3 (condition). Channel B uses 4, 5, 6 and 7.
- R3: The footprint is the aligned span of the operand size, so span is 0 for a byte, 1 for a word and 3 for a longword. With break address 0x00123456, a longword at 0x00123454 and a word or byte at 0x00123456 all hit. A byte at 0x00123457 and a word at 0x00123454 miss.
- R4: A hit requires `cyc_asid` to equal the channel's 8-bit identifier register.
- R5: In the condition word, bits [1:0] select the master (bit 0 CPU, bit 1 DMA). Bits [3:2] select the kind (bit 2 fetch, bit 3 data). Bits [5:4] select the direction (bit 4 read, bit 5 write). A cycle hits only if the bit for its own master, kind and direction is set.
- R6: Condition bits [7:6] select the size: 0 means any size, 1 byte, 2 word, 3 longword. `cyc_size` uses 0 for byte, 1 for word and 2 for longword.
- R7: A cycle that claims a DMA instruction fetch (`cyc_dma`=1, `cyc_data_acc`=0) never hits on either channel, whatever the condition says.
- R8: Channel B enables its data compare with condition bit 8, break data at index 8 and data mask at index 9 (mask bit 1 = ignore). A byte compares lane `cyc_addr[1:0]` (bits 8k+7:8k) against bits [7:0]. A word compares bits [15:0], and a longword compares all 32 bits. Channel A never compares data.
- R9: When its data compare is enabled, channel B hits on a read only if `cyc_data_ok` is 1. On a write `cyc_data_ok` is not needed.
- R10: A hit sets the channel's flag at the clock edge that samples the cycle. The flag stays set until it is cleared. `brk_req` is 1 whenever either flag is 1, and each channel sets its flag independently of the other.
- R11: A write to index 15 clears flag A if data bit 0 is 0 and flag B if data bit 1 is 0. A bit of 1 leaves its flag unchanged. A hit in the same cycle as a clear leaves the flag set.
- R12: A register write takes effect for bus cycles sampled on later clock edges. A cycle sampled together with the write is judged against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | A bus cycle is present this clock |
| cyc_addr | input | 32 | Cycle address |
| cyc_asid | input | 8 | Address-space identifier of the cycle |
| cyc_dma | input | 1 | 1 = DMA controller, 0 = CPU |
| cyc_data_acc | input | 1 | 1 = data access, 0 = instruction fetch |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_size | input | 2 | 0 byte, 1 word, 2 longword |
| cyc_data | input | 32 | Bus data |
| cyc_data_ok | input | 1 | Read data is valid this clock |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| brk_flag | output | 2 | Sticky flags, bit 0 channel A, bit 1 channel B |
| brk_req | output | 1 | Combined break request |

## Verification
Two events can land on the same clock. A software clear can meet a new matching cycle on the same channel, and a register write can meet a bus cycle that the old or the new value would judge differently. The bench provokes the first by driving a status write with the channel's bit at 0 together with a matching cycle, and expects the flag to stay set. It provokes the second by changing the identifier register in the same cycle as a bus cycle carrying the old identifier. That cycle must still hit, and the cycle after it must miss.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int ID_W    = 8;
    localparam int NCH     = 2;
    localparam int IDX_W   = 4;
    localparam int REGS_CH = 4;
    localparam logic [IDX_W-1:0] IDX_BDATA = 4'd8;
    localparam logic [IDX_W-1:0] IDX_BMASK = 4'd9;
    localparam logic [IDX_W-1:0] IDX_STAT  = 4'd15;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} size_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   asid;
        logic              dma;
        logic              data_acc;
        logic              write;
        logic [1:0]        size;
        logic [DATA_W-1:0] data;
        logic              data_ok;
    } cyc_t;

    typedef struct packed {
        logic       den;
        logic [1:0] size_sel;
        logic [1:0] dir_sel;
        logic [1:0] kind_sel;
        logic [1:0] master_sel;
    } cond_t;

    localparam int COND_W = $bits(cond_t);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] amask;
        logic [ID_W-1:0]   asid;
        cond_t             cond;
        logic [DATA_W-1:0] bdata;
        logic [DATA_W-1:0] dmask;
    } chan_cfg_t;

    function automatic logic [ADDR_W-1:0] span_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: span_mask = '0;
            SZ_WORD: span_mask = ADDR_W'(1);
            default: span_mask = ADDR_W'(3);
        endcase
    endfunction

    function automatic logic data_match(input logic [1:0] sz, input logic [1:0] lane,
                                        input logic [DATA_W-1:0] bus,
                                        input logic [DATA_W-1:0] ref_v,
                                        input logic [DATA_W-1:0] msk);
        logic [DATA_W-1:0] shifted;
        shifted = bus >> {lane, 3'b000};
        case (sz)
            SZ_BYTE: data_match = ((shifted[7:0] ^ ref_v[7:0]) & ~msk[7:0]) == '0;
            SZ_WORD: data_match = ((bus[15:0] ^ ref_v[15:0]) & ~msk[15:0]) == '0;
            default: data_match = ((bus ^ ref_v) & ~msk) == '0;
        endcase
    endfunction
endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  logic [DATA_W-1:0]        wdata,
    output chan_cfg_t [NCH-1:0]      cfg_o
);
    logic [DATA_W-1:0] bdata_q, dmask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bdata_q <= '0;
            dmask_q <= '0;
        end else if (we) begin
            if (idx == IDX_BDATA) bdata_q <= wdata;
            if (idx == IDX_BMASK) dmask_q <= wdata;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [IDX_W-1:0] BASE = IDX_W'(c * REGS_CH);
        logic [ADDR_W-1:0] addr_q, amask_q;
        logic [ID_W-1:0]   asid_q;
        cond_t             cond_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q  <= '0;
                amask_q <= '0;
                asid_q  <= '0;
                cond_q  <= '0;
            end else if (we) begin
                if (idx == BASE)         addr_q  <= wdata[ADDR_W-1:0];
                if (idx == BASE + 4'd1)  amask_q <= wdata[ADDR_W-1:0];
                if (idx == BASE + 4'd2)  asid_q  <= wdata[ID_W-1:0];
                if (idx == BASE + 4'd3)  cond_q  <= cond_t'(wdata[COND_W-1:0]);
            end
        end

        always_comb begin
            cfg_o[c].addr  = addr_q;
            cfg_o[c].amask = amask_q;
            cfg_o[c].asid  = asid_q;
            cfg_o[c].cond  = cond_q;
            cfg_o[c].bdata = (c == NCH - 1) ? bdata_q : '0;
            cfg_o[c].dmask = (c == NCH - 1) ? dmask_q : '0;
        end

        assert_write_lands_R12: assert property (@(posedge clk) disable iff (rst)
            (we && idx == BASE + 4'd3) |=> (cond_q == cond_t'($past(wdata[COND_W-1:0]))));
    end
endmodule

// File: rtl/brk_channel.sv
module brk_channel
    import brk_pkg::*;
#(
    parameter bit HAS_DATA = 1'b1
)(
    input  logic      clk,
    input  logic      rst,
    input  cyc_t      cyc_i,
    input  chan_cfg_t cfg_i,
    input  logic      clr_i,
    output logic      flag_o
);
    logic addr_ok, asid_ok, master_ok, kind_ok, dir_ok, size_ok, possible, data_ok, hit;
    logic [ADDR_W-1:0] eff_mask;

    always_comb begin
        eff_mask  = cfg_i.amask | span_mask(cyc_i.size);
        addr_ok   = ((cyc_i.addr ^ cfg_i.addr) & ~eff_mask) == '0;
        asid_ok   = cyc_i.asid == cfg_i.asid;
        master_ok = cfg_i.cond.master_sel[cyc_i.dma];
        kind_ok   = cfg_i.cond.kind_sel[cyc_i.data_acc];
        dir_ok    = cfg_i.cond.dir_sel[cyc_i.write];
        size_ok   = (cfg_i.cond.size_sel == 2'd0) ||
                    (cfg_i.cond.size_sel == 2'(cyc_i.size + 2'd1));
        possible  = !(cyc_i.dma && !cyc_i.data_acc);
    end

    if (HAS_DATA) begin : g_data
        always_comb begin
            data_ok = !cfg_i.cond.den ||
                      ((cyc_i.write || cyc_i.data_ok) &&
                       data_match(cyc_i.size, cyc_i.addr[1:0], cyc_i.data,
                                  cfg_i.bdata, cfg_i.dmask));
        end
    end else begin : g_nodata
        assign data_ok = 1'b1;
    end

    assign hit = cyc_i.valid && possible && addr_ok && asid_ok && master_ok &&
                 kind_ok && dir_ok && size_ok && data_ok;

    always_ff @(posedge clk) begin
        if (rst) flag_o <= 1'b0;
        else     flag_o <= (flag_o && !clr_i) || hit;
    end

    assert_unarmed_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.cond.dir_sel == 2'b00) |=> !$rose(flag_o));
    assert_dma_fetch_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (cyc_i.valid && cyc_i.dma && !cyc_i.data_acc) |=> !$rose(flag_o));
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);
    assert_clear_drops_R11: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !hit) |=> !flag_o);
endmodule

// File: rtl/brk_compare_unit.sv
module brk_compare_unit
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_valid,
    input  logic [31:0]       cyc_addr,
    input  logic [7:0]        cyc_asid,
    input  logic              cyc_dma,
    input  logic              cyc_data_acc,
    input  logic              cyc_write,
    input  logic [1:0]        cyc_size,
    input  logic [31:0]       cyc_data,
    input  logic              cyc_data_ok,
    input  logic              reg_we,
    input  logic [3:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [1:0]        brk_flag,
    output logic              brk_req
);
    cyc_t               cyc;
    chan_cfg_t [NCH-1:0] cfg;
    logic [NCH-1:0]     clr;

    always_comb begin
        cyc.valid    = cyc_valid;
        cyc.addr     = cyc_addr;
        cyc.asid     = cyc_asid;
        cyc.dma      = cyc_dma;
        cyc.data_acc = cyc_data_acc;
        cyc.write    = cyc_write;
        cyc.size     = cyc_size;
        cyc.data     = cyc_data;
        cyc.data_ok  = cyc_data_ok;
    end

    brk_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .cfg_o (cfg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign clr[c] = reg_we && (reg_idx == IDX_STAT) && !reg_wdata[c];
        brk_channel #(.HAS_DATA(c == NCH - 1)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .cyc_i  (cyc),
            .cfg_i  (cfg[c]),
            .clr_i  (clr[c]),
            .flag_o (brk_flag[c])
        );
    end

    assign brk_req = |brk_flag;

    assert_req_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_req) |-> $past(cyc_valid));
endmodule

// File: tb/brk_compare_unit_test.sv
module brk_compare_unit_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_valid = 0, cyc_dma = 0, cyc_data_acc = 0, cyc_write = 0, cyc_data_ok = 0;
    logic [31:0] cyc_addr = '0, cyc_data = '0, reg_wdata = '0;
    logic [7:0]  cyc_asid = '0;
    logic [1:0]  cyc_size = '0;
    logic        reg_we = 0;
    logic [3:0]  reg_idx = '0;
    logic [1:0]  brk_flag;
    logic        brk_req;

    typedef struct {
        logic  fa;
        logic  fb;
        string tag;
    } exp_t;
    exp_t q[$];

    int   n_cmp = 0, n_bad = 0;
    logic ea = 0, eb = 0;
    logic done = 0;

    always #(PERIOD/2) clk = ~clk;

    brk_compare_unit uut (
        .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .cyc_asid(cyc_asid), .cyc_dma(cyc_dma), .cyc_data_acc(cyc_data_acc),
        .cyc_write(cyc_write), .cyc_size(cyc_size), .cyc_data(cyc_data),
        .cyc_data_ok(cyc_data_ok), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .brk_flag(brk_flag), .brk_req(brk_req)
    );

    // monitor: one expected item per driven clock, judged just after the edge
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (brk_flag !== {e.fb, e.fa} || brk_req !== (e.fa | e.fb)) begin
                n_bad++;
                $display("FAIL %s: flags=%b req=%b expected flags=%b req=%b",
                         e.tag, brk_flag, brk_req, {e.fb, e.fa}, e.fa | e.fb);
            end
        end
    end

    task automatic go(input logic ha, input logic hb, input string tag);
        if (reg_we && reg_idx == 4'd15) begin
            ea = ea & reg_wdata[0];
            eb = eb & reg_wdata[1];
        end
        ea = ea | ha;
        eb = eb | hb;
        q.push_back('{ea, eb, tag});
        @(negedge clk);
        cyc_valid = 0;
        reg_we = 0;
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] v, input string tag);
        reg_we = 1; reg_idx = i; reg_wdata = v;
        go(0, 0, tag);
    endtask

    task automatic bus(input logic [31:0] a, input logic [7:0] id, input logic dma,
                       input logic dacc, input logic w, input logic [1:0] sz,
                       input logic [31:0] d, input logic dok);
        cyc_valid = 1; cyc_addr = a; cyc_asid = id; cyc_dma = dma;
        cyc_data_acc = dacc; cyc_write = w; cyc_size = sz; cyc_data = d; cyc_data_ok = dok;
    endtask

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: expected completion, run hung");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state, unprogrammed channels stay quiet
        go(0, 0, "R1 reset idle");
        bus(32'h0, 8'h00, 0, 1, 0, 0, 32'h0, 1); go(0, 0, "R1 unarmed");
        bus(32'h0, 8'h00, 0, 1, 1, 2, 32'h0, 1); go(0, 0, "R1 unarmed write");

        // channel A: CPU data read any size; channel B: CPU data word write with data
        wr(4'd0, 32'h0012_3456, "cfg"); wr(4'd1, 32'h0, "cfg");
        wr(4'd2, 32'h80, "cfg");        wr(4'd3, 32'h019, "cfg");
        wr(4'd4, 32'h000A_BCDE, "cfg"); wr(4'd5, 32'hFF, "cfg");
        wr(4'd6, 32'h70, "cfg");        wr(4'd7, 32'h1A9, "cfg");
        wr(4'd8, 32'hA512, "cfg");      wr(4'd9, 32'h0, "cfg");

        bus(32'h0012_3454, 8'h80, 0, 1, 0, 2, 0, 1); go(1, 0, "R3 long covers");
        go(0, 0, "R10 sticky idle");
        wr(4'd15, 32'h2, "R11 clear A");
        bus(32'h0012_3456, 8'h80, 0, 1, 0, 1, 0, 1); go(1, 0, "R3 word exact");
        wr(4'd15, 32'h2, "R11 clear A");
        bus(32'h0012_3456, 8'h80, 0, 1, 0, 0, 0, 1); go(1, 0, "R3 byte exact");
        wr(4'd15, 32'h2, "R11 clear A");
        bus(32'h0012_3457, 8'h80, 0, 1, 0, 0, 0, 1); go(0, 0, "R3 byte beside");
        bus(32'h0012_3454, 8'h80, 0, 1, 0, 1, 0, 1); go(0, 0, "R3 word beside");
        bus(32'h0012_3454, 8'h81, 0, 1, 0, 2, 0, 1); go(0, 0, "R4 asid differs");
        bus(32'h0012_3454, 8'h80, 0, 1, 1, 2, 0, 1); go(0, 0, "R5 wrong dir");
        bus(32'h0012_3454, 8'h80, 1, 1, 0, 2, 0, 1); go(0, 0, "R5 wrong master");
        bus(32'h0012_3454, 8'h80, 0, 0, 0, 2, 0, 1); go(0, 0, "R5 wrong kind");

        bus(32'h000A_BC00, 8'h70, 0, 1, 1, 1, 32'hA512, 0); go(0, 1, "R2 mask low end");
        wr(4'd15, 32'h1, "R11 clear B");
        bus(32'h000A_BCFE, 8'h70, 0, 1, 1, 1, 32'hA512, 0); go(0, 1, "R2 mask high end");
        wr(4'd15, 32'h1, "R11 clear B");
        bus(32'h000A_BD00, 8'h70, 0, 1, 1, 1, 32'hA512, 0); go(0, 0, "R2 outside mask");
        bus(32'h000A_BC10, 8'h70, 0, 1, 1, 0, 32'h12, 0);   go(0, 0, "R6 byte vs word");
        bus(32'h000A_BC10, 8'h70, 0, 1, 1, 1, 32'hA513, 0); go(0, 0, "R8 data differs");
        bus(32'h000A_BC10, 8'h71, 0, 1, 1, 1, 32'hA512, 0); go(0, 0, "R4 asid B");
        bus(32'h000A_BC10, 8'h70, 0, 1, 1, 1, 32'hFFFF_A512, 0); go(0, 1, "R8 word low half");
        wr(4'd15, 32'h1, "R11 clear B");

        // R9: reads need valid data
        wr(4'd7, 32'h1B9, "cfg");
        bus(32'h000A_BC20, 8'h70, 0, 1, 0, 1, 32'hA512, 0); go(0, 0, "R9 read no data");
        bus(32'h000A_BC20, 8'h70, 0, 1, 0, 1, 32'hA512, 1); go(0, 1, "R9 read data ok");
        wr(4'd15, 32'h1, "R11 clear B");

        // R8: byte lane compare under mask, DMA byte write
        wr(4'd4, 32'h0005_5555, "cfg"); wr(4'd5, 32'h0, "cfg");
        wr(4'd7, 32'h16A, "cfg");
        wr(4'd8, 32'h78, "cfg");        wr(4'd9, 32'h0F, "cfg");
        bus(32'h0005_5555, 8'h70, 1, 1, 1, 0, 32'h0000_7300, 0); go(0, 1, "R8 byte lane masked");
        wr(4'd15, 32'h1, "R11 clear B");
        bus(32'h0005_5555, 8'h70, 1, 1, 1, 0, 32'h0000_8300, 0); go(0, 0, "R8 byte outside mask");
        bus(32'h0005_5555, 8'h70, 1, 1, 1, 0, 32'h0000_0073, 0); go(0, 0, "R8 wrong lane");
        bus(32'h0005_5555, 8'h70, 0, 1, 1, 0, 32'h0000_7300, 0); go(0, 0, "R5 CPU not DMA");

        // R7: DMA fetch never matches
        wr(4'd0, 32'h0031_4156, "cfg"); wr(4'd3, 32'h016, "cfg");
        bus(32'h0031_4156, 8'h80, 1, 0, 0, 1, 0, 1); go(0, 0, "R7 dma fetch cond");
        wr(4'd3, 32'h017, "cfg");
        bus(32'h0031_4156, 8'h80, 1, 0, 0, 1, 0, 1); go(0, 0, "R7 dma fetch either");
        bus(32'h0031_4156, 8'h80, 0, 0, 0, 1, 0, 1); go(1, 0, "R5 cpu fetch");

        // R10/R11: independence, write-one keeps, set beats clear
        bus(32'h0005_5555, 8'h70, 1, 1, 1, 0, 32'h0000_7F00, 0); go(0, 1, "R10 B while A set");
        wr(4'd15, 32'h3, "R11 ones keep");
        reg_we = 1; reg_idx = 4'd15; reg_wdata = 32'h1;
        bus(32'h0005_5555, 8'h70, 1, 1, 1, 0, 32'h0000_7000, 0); go(0, 1, "R11 set wins clear");
        wr(4'd15, 32'h0, "R11 clear both");

        // R6: longword only; R8: channel A ignores data
        wr(4'd3, 32'h1D7, "cfg");
        bus(32'h0031_4156, 8'h80, 0, 0, 0, 1, 0, 1); go(0, 0, "R6 word vs long");
        bus(32'h0031_4154, 8'h80, 0, 0, 0, 2, 32'hDEAD_BEEF, 0); go(1, 0, "R6 long, R8 A no data");
        wr(4'd15, 32'h0, "R11 clear both");

        // R12: write and cycle together use old identifier
        reg_we = 1; reg_idx = 4'd2; reg_wdata = 32'h90;
        bus(32'h0031_4154, 8'h80, 0, 0, 0, 2, 0, 1); go(1, 0, "R12 old value");
        wr(4'd15, 32'h2, "R11 clear A");
        bus(32'h0031_4154, 8'h80, 0, 0, 0, 2, 0, 1); go(0, 0, "R12 old id gone");
        bus(32'h0031_4154, 8'h90, 0, 0, 0, 2, 0, 1); go(1, 0, "R12 new id");

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule